// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 32-bit logical address into a 41-bit physical address using a single-level page table kept in memory. The logical address splits into a 23-bit page selector (upper bits) and a 9-bit byte offset (lower bits), so a page holds 512 bytes. The selector indexes a per-process table whose base address sits in a register. Each table entry is 8 bytes. Its upper 32-bit word names a physical frame and its lower 32-bit word holds control bits.

A translation starts with a request/response handshake. The block reads the entry as two 32-bit bus beats, low word first. It then checks the valid bit and either returns `{frame, offset}` or flags a page fault. A process still sees only 2^32 logical bytes, but frames can lie anywhere in a 2^41-byte physical space.

The controller has four states:
- ST_IDLE accepts a request and moves to ST_FETCH_LO.
- ST_FETCH_LO issues the low-word read and waits for its data, then moves to ST_FETCH_HI.
- ST_FETCH_HI does the same for the high word, then moves to ST_RESPOND.
- ST_RESPOND holds the result until it is taken, then returns to ST_IDLE.

The table base is loaded through a separate write port. That port takes effect only in ST_IDLE.

Top module: `page_xlate`

## Requirements
- R1: After reset the block is in ST_IDLE with `req_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0.
- R2: The low-word read address is `{base[40:3],3'b000} + selector*8`, where selector = `laddr[31:9]`. The high-word read address is that value plus 4. Every read address has bits [1:0] equal to 0.
- R3: Exactly two memory reads are made per translation: the low word first, then the high word. The second read is issued only after the first one's data has returned.
- R4: For a valid entry, `rsp_paddr` equals `{high word, laddr[8:0]}` and `rsp_fault`=0.
- R5: Bit 0 of the low (control) word is the valid bit. When it is 0, `rsp_fault`=1 and `rsp_paddr` is all zeros.
- R6: `rsp_ctrl` returns the full 32-bit low (control) word of the entry, whether or not the entry is valid.
- R7: A base write while a translation is in progress (any state other than ST_IDLE) is ignored. A base write in ST_IDLE applies to the next translation.
- R8: `req_ready` is 0 outside ST_IDLE. Once `rsp_valid` rises, it and `rsp_paddr`, `rsp_fault` and `rsp_ctrl` stay stable until a cycle with `rsp_ready`=1.
- R9: A read request (`mem_req_valid`, `mem_addr`) is held stable until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | 41 | New table base (low 3 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 32 | Logical address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_addr | output | 41 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 41 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page fault: entry not valid |
| rsp_ctrl | output | 32 | Control word of the entry |

## Verification
The hardest case to reach from the ports is a base write that lands in the middle of a table walk. It must be ignored, and the only visible effect is the read address of the next translation. To reach it, the bench writes a new base while a walk is stalled on memory, then checks every read address of that walk and the following one. Random memory accept delays, read latencies and response back-pressure push each state through its waiting branches. A searched selector sets the valid bit to each value on demand.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
    localparam int LA_W        = 32;
    localparam int OFF_W       = 9;
    localparam int SEL_W       = LA_W - OFF_W;
    localparam int WORD_W      = 32;
    localparam int FRAME_W     = WORD_W;
    localparam int PA_W        = FRAME_W + OFF_W;
    localparam int ENTRY_BYTES = 8;
    localparam int IDX_SH      = $clog2(ENTRY_BYTES);
    localparam int WORD_SH     = $clog2(WORD_W / 8);
    localparam int VALID_BIT   = 0;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2,
        ST_RESPOND  = 2'd3
    } xl_state_t;
endpackage

// File: rtl/pxl_base_reg.sv
module pxl_base_reg
    import page_xlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PA_W-1:0] wr_data,
    input  logic            busy,
    output logic [PA_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en && !busy) begin
            base_q <= {wr_data[PA_W-1:IDX_SH], {IDX_SH{1'b0}}};
        end
    end

    // R7: base frozen while a walk is in flight
    p_base_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q));
endmodule

// File: rtl/pxl_fsm.sv
module pxl_fsm
    import page_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      mem_req_ready,
    input  logic      mem_rvalid,
    input  logic      rsp_ready,
    output xl_state_t state,
    output logic      req_ready,
    output logic      mem_req_valid,
    output logic      cap_req,
    output logic      cap_lo,
    output logic      cap_hi,
    output logic      rsp_valid,
    output logic      busy
);
    xl_state_t state_d;
    logic      issued_q, issued_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            issued_q <= 1'b0;
        end else begin
            state    <= state_d;
            issued_q <= issued_d;
        end
    end

    always_comb begin
        state_d       = state;
        issued_d      = issued_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        cap_req       = 1'b0;
        cap_lo        = 1'b0;
        cap_hi        = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    cap_req = 1'b1;
                    state_d = ST_FETCH_LO;
                end
            end
            ST_FETCH_LO: begin
                mem_req_valid = !issued_q;
                if (!issued_q && mem_req_ready) issued_d = 1'b1;
                if (issued_q && mem_rvalid) begin
                    cap_lo   = 1'b1;
                    issued_d = 1'b0;
                    state_d  = ST_FETCH_HI;
                end
            end
            ST_FETCH_HI: begin
                mem_req_valid = !issued_q;
                if (!issued_q && mem_req_ready) issued_d = 1'b1;
                if (issued_q && mem_rvalid) begin
                    cap_hi   = 1'b1;
                    issued_d = 1'b0;
                    state_d  = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        busy = (state != ST_IDLE);
    end

    // R9: read request held until accepted
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
    // R8: response held until taken
    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid);
    // R3: after the low beat captures, the next state fetches the high word
    p_lo_then_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lo |=> (state == ST_FETCH_HI));
endmodule

// File: rtl/pxl_datapath.sv
module pxl_datapath
    import page_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  xl_state_t         state,
    input  logic [PA_W-1:0]   base_q,
    input  logic              cap_req,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [LA_W-1:0]   req_laddr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_req_valid,
    input  logic              rsp_valid,
    output logic [PA_W-1:0]   mem_addr,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [WORD_W-1:0] rsp_ctrl
);
    logic [LA_W-1:0]   laddr_q;
    logic [WORD_W-1:0] ctrl_q;
    logic [FRAME_W-1:0] frame_q;
    logic [SEL_W-1:0]  sel;
    logic [PA_W-1:0]   entry_addr;
    logic              hi_phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q <= '0;
            ctrl_q  <= '0;
            frame_q <= '0;
        end else begin
            if (cap_req) laddr_q <= req_laddr;
            if (cap_lo)  ctrl_q  <= mem_rdata;
            if (cap_hi)  frame_q <= mem_rdata;
        end
    end

    always_comb begin
        sel        = laddr_q[LA_W-1:OFF_W];
        hi_phase   = (state == ST_FETCH_HI);
        entry_addr = base_q + (PA_W'(sel) << IDX_SH);
        mem_addr   = entry_addr | (hi_phase ? PA_W'(1 << WORD_SH) : '0);
        rsp_fault  = !ctrl_q[VALID_BIT];
        rsp_ctrl   = ctrl_q;
        rsp_paddr  = rsp_fault ? '0 : {frame_q, laddr_q[OFF_W-1:0]};
    end

    // R2: read addresses are word aligned and the half is picked by the phase
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_addr[WORD_SH-1:0] == '0 && mem_addr[WORD_SH] == hi_phase));
    // R8: result stable while waiting for the consumer
    p_rsp_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid)) |-> ($stable(rsp_paddr) && $stable(rsp_ctrl)));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import page_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [PA_W-1:0]   base_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LA_W-1:0]   req_laddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [WORD_W-1:0] rsp_ctrl
);
    xl_state_t       state;
    logic            busy, cap_req, cap_lo, cap_hi;
    logic [PA_W-1:0] base_q;

    pxl_base_reg u_base (
        .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en), .wr_data(base_wr_data),
        .busy(busy), .base_q(base_q)
    );

    pxl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_req_ready(mem_req_ready),
        .mem_rvalid(mem_rvalid), .rsp_ready(rsp_ready), .state(state),
        .req_ready(req_ready), .mem_req_valid(mem_req_valid), .cap_req(cap_req),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .rsp_valid(rsp_valid), .busy(busy)
    );

    pxl_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .state(state), .base_q(base_q), .cap_req(cap_req),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .req_laddr(req_laddr), .mem_rdata(mem_rdata),
        .mem_req_valid(mem_req_valid), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_ctrl(rsp_ctrl)
    );

    // R1/R8: no new request accepted while a result is pending
    p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R5: a fault never carries an address
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: tb/page_xlate_test.sv
module page_xlate_test;
    import page_xlate_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_wr_en = 1'b0;
    logic [PA_W-1:0] base_wr_data = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LA_W-1:0] req_laddr = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic rsp_valid;
    logic rsp_ready = 1'b0;
    logic [PA_W-1:0] rsp_paddr;
    logic rsp_fault;
    logic [WORD_W-1:0] rsp_ctrl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [PA_W-1:0] exp_entry;
    int beat = 0;

    always #2 clk = ~clk;

    page_xlate uut (
        .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_ctrl(rsp_ctrl)
    );

    function automatic logic [WORD_W-1:0] mem_word(input logic [PA_W-1:0] a);
        return (a[31:0] * 32'h9E3779B1) ^ {a[40:32], 23'h0} ^ (a[31:0] >> 5);
    endfunction

    function automatic logic [PA_W-1:0] entry_of(input logic [PA_W-1:0] b, input logic [LA_W-1:0] la);
        return {b[PA_W-1:3], 3'b000} + ({18'h0, la[31:9]} * 41'd8);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model, checks read order and addresses (R2, R3)
    initial begin
        bit acc = 0, pend = 0;
        int lat = 0;
        logic [PA_W-1:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (acc) begin
                acc = 0;
                mem_req_ready = 1'b0;
                pend = 1;
                lat = $urandom % 3;
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_word(a);
                    pend = 0;
                end else lat--;
            end else if (mem_req_valid && ($urandom % 2 == 1)) begin
                a = mem_addr;
                mem_req_ready = 1'b1;
                acc = 1;
                check(beat == 0 ? "R2 low word address" : "R3 high word address",
                      64'(mem_addr), 64'(exp_entry + (beat == 0 ? 41'd0 : 41'd4)));
                beat++;
            end
        end
    end

    task automatic translate(input logic [PA_W-1:0] bexp, input logic [LA_W-1:0] la,
                             input bit mid_write, input logic [PA_W-1:0] wval);
        logic [WORD_W-1:0] lo, hi;
        logic [PA_W-1:0] pa;
        logic f;
        int stall;
        exp_entry = entry_of(bexp, la);
        beat = 0;
        lo = mem_word(exp_entry);
        hi = mem_word(exp_entry + 41'd4);
        f = !lo[0];
        pa = f ? '0 : {hi, la[8:0]};
        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 req_ready low while busy", 64'(req_ready), 64'd0);
        if (mid_write) begin
            base_wr_en = 1'b1;
            base_wr_data = wval;
            @(negedge clk);
            base_wr_en = 1'b0;
        end
        while (!rsp_valid && !done) @(negedge clk);
        check("R3 two reads per walk", 64'(beat), 64'd2);
        stall = $urandom % 3;
        for (int i = 0; i <= stall; i++) begin
            if (i > 0) @(negedge clk);
            check("R8 rsp_valid held", 64'(rsp_valid), 64'd1);
            check(f ? "R5 fault address zero" : "R4 physical address", 64'(rsp_paddr), 64'(pa));
            check("R5 fault flag", 64'(rsp_fault), 64'(f));
            check("R6 control word", 64'(rsp_ctrl), 64'(lo));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R8 response dropped after take", 64'(rsp_valid), 64'd0);
    endtask

    task automatic set_base(input logic [PA_W-1:0] b);
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    function automatic logic [LA_W-1:0] find_la(input logic [PA_W-1:0] b, input bit want_valid,
                                                input logic [LA_W-1:0] start);
        logic [LA_W-1:0] la = start;
        for (int i = 0; i < 64; i++) begin
            if (mem_word(entry_of(b, la))[0] == want_valid) return la;
            la = la + 32'h200;
        end
        return la;
    endfunction

    initial begin
        logic [PA_W-1:0] b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        check("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle ready", 64'(req_ready), 64'd1);

        b = 41'h1_0000_0005;
        set_base(b);
        translate(b, find_la(b, 1, 32'h0000_0000), 0, '0);           // R4 selector 0 region
        translate(b, find_la(b, 0, 32'h0000_01FF), 0, '0);           // R5 invalid entry
        translate(b, 32'hFFFF_FFFF, 0, '0);                          // R2 maximum selector
        b = 41'h1FF_FFFF_FFF8;
        set_base(b);
        translate(b, 32'hFFFF_FE00, 0, '0);                          // R2 carry near top
        b = 41'h0_0400_0000;
        set_base(b);
        translate(b, 32'h1234_5678, 1, 41'h0_0800_0000);             // R7 write ignored
        translate(b, 32'h1234_5678, 0, '0);                          // R7 old base still used
        b = 41'h0_0800_0000;
        set_base(b);
        translate(b, 32'h1234_5678, 0, '0);                          // R7 idle write applies
        for (int n = 0; n < 60; n++) begin
            if (n % 15 == 0) begin
                b = {$urandom, $urandom} & 41'h1FF_FFFF_FFFF;
                set_base(b);
            end
            translate(b, $urandom, 0, '0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule